// File: doc/BRIEF.md
# Command-Driven HDLC Frame Transmitter

This block turns bytes that a processor deposits in a small transmit queue into a serial HDLC bit stream. The processor writes a chunk of bytes and then issues single-cycle command strobes. One strobe starts a framed transmission. A second starts a transparent (unframed) transmission. A third declares that the most recent chunk closes the message. A fourth resets the transmitter. In framed mode the block sends the opening flag, inserts zero bits for transparency and appends a CRC-16 frame check sequence and a closing flag. Between frames it sends interframe fill.

A long message crosses the queue in several chunks. Each time the queue drains before the end of the message has been declared, the block pulses an interrupt so that software can supply the next chunk. If software is too late, the block flags an underrun and aborts the frame on the line. The reset command can be issued at any moment. It empties the queue, sends an abort pattern, returns to fill, and reports its completion with the same pool-ready interrupt. The line advances one bit per clock-enable pulse.

Top module: `hdlc_cmd_tx`

## Requirements
- R1: Out of reset `tx_bit` is 1, and the idle line carries back-to-back flags 0x7E sent LSB first (bit pattern 0,1,1,1,1,1,1,0). While `idle_ones` is 1, each fill byte that starts is all ones instead.
- R2: A framed transmission sends one opening flag and then the queued bytes LSB first. After every run of five consecutive 1s in the data and check sequence, a 0 is inserted.
- R3: After the last byte of a framed message, the block sends the ones' complement of CRC-16 (polynomial x^16+x^12+x^5+1, processed bit-reflected as 0x8408, preset 0xFFFF) LSB first, then a closing flag, then fill.
- R4: A transparent transmission sends the queued bytes LSB first with no flags, no inserted zeros and no check sequence, then returns to fill.
- R5: When a byte leaves the queue and empties it while no message end is pending, `pool_irq` pulses for one cycle. Bytes written afterwards continue the same frame. A message that is complete when started produces no such pulse.
- R6: If the next byte is needed while the queue is empty and no message end is pending, `underrun_irq` pulses. The line then carries seven 1s, followed by fill.
- R7: `cmd_reset` empties the queue, discards pending commands and aborts the current output. The next seven bit periods (including the reset cycle itself when `bit_en` is high) carry 1s, then fill. `pool_irq` pulses once the abort pattern is complete.
- R8: `tx_bit` changes only on a clock edge at which `bit_en` is high.
- R9: The queue holds DEPTH bytes (32 by default). Writes to a full queue are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Advance the serial output by one bit |
| idle_ones | input | 1 | 1 selects all-ones fill, 0 selects flag fill |
| wr_en | input | 1 | Push `wr_data` into the transmit queue |
| wr_data | input | 8 | Byte to queue |
| cmd_frame | input | 1 | Strobe: start framed transmission |
| cmd_transp | input | 1 | Strobe: start transparent transmission |
| cmd_msg_end | input | 1 | Strobe: queued data completes the message |
| cmd_reset | input | 1 | Strobe: clear queue and abort |
| tx_bit | output | 1 | Serial line output |
| pool_irq | output | 1 | One-cycle pulse: queue can take the next chunk, or reset finished |
| underrun_irq | output | 1 | One-cycle pulse: frame aborted because the queue ran dry |

## Verification
The hardest situations to reach are those in which software timing interacts with the bit clock. Examples are a queue that drains mid-frame and is refilled within the eight-bit grace window, one that is not refilled, and a reset strobe that lands on the same edge as a `bit_en` pulse. The bench reaches them by reacting to `pool_irq` with a second chunk in one case and deliberately withholding it in another. It issues the reset with `bit_en` high every cycle, so the strobe is certain to coincide with an output step. Random frames with an added share of 0xFF bytes force zero insertion across the data-to-check-sequence boundary and before the closing flag.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;
  localparam logic [7:0]  FLAG_BYTE  = 8'h7E;
  localparam logic [15:0] CRC_PRESET = 16'hFFFF;
  localparam logic [15:0] CRC_POLY_R = 16'h8408;
  localparam logic [2:0]  STUFF_RUN  = 3'd5;

  typedef enum logic [2:0] {
    S_FILL, S_OPEN, S_DATA, S_CRC, S_CLOSE, S_ABORT
  } tx_state_e;

  // one serial step of the reflected CRC-16 register
  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
    crc_step = {1'b0, c[15:1]} ^ (((c[0] ^ b) == 1'b1) ? CRC_POLY_R : 16'h0000);
  endfunction

  // length of the current run of ones after bit b
  function automatic logic [2:0] run_next(input logic [2:0] run, input logic b);
    run_next = b ? run + 3'd1 : 3'd0;
  endfunction
endpackage

// File: rtl/hdlc_tx_fifo.sv
module hdlc_tx_fifo #(
  parameter int DEPTH = 32,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         rd,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         last
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          full, do_wr, do_rd;

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
  assign last  = (count == CW'(1));
  assign do_wr = wr && !full && !clr;
  assign do_rd = rd && !empty && !clr;
  assign rdata = mem[rd_ptr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    bump = (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_wr) wr_ptr <= bump(wr_ptr);
      if (do_rd) rd_ptr <= bump(rd_ptr);
      case ({do_wr, do_rd})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  // R9: a write into a full queue leaves it full and adds nothing
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr && !rd && !clr) |=> full);

  p_pop_nonempty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd |-> !empty);
endmodule

// File: rtl/hdlc_tx_cmd.sv
module hdlc_tx_cmd (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_frame,
  input  logic cmd_transp,
  input  logic cmd_msg_end,
  input  logic cmd_reset,
  input  logic take_start,
  input  logic take_end,
  output logic start_req,
  output logic transp_req,
  output logic end_req
);
  logic start_q, transp_q, end_q;

  always_ff @(posedge clk) begin
    if (!rst_n || cmd_reset) begin
      start_q  <= 1'b0;
      transp_q <= 1'b0;
      end_q    <= 1'b0;
    end else begin
      if (take_start) begin
        start_q  <= 1'b0;
        transp_q <= 1'b0;
      end else begin
        if (cmd_frame)  start_q  <= 1'b1;
        if (cmd_transp) transp_q <= 1'b1;
      end
      if (take_end)         end_q <= 1'b0;
      else if (cmd_msg_end) end_q <= 1'b1;
    end
  end

  // a strobe counts in the cycle it arrives
  assign start_req  = (start_q  || cmd_frame)   && !cmd_reset;
  assign transp_req = (transp_q || cmd_transp)  && !cmd_reset;
  assign end_req    = (end_q    || cmd_msg_end) && !cmd_reset;
endmodule

// File: rtl/hdlc_tx_serial.sv
module hdlc_tx_serial
  import hdlc_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  input  logic       idle_ones,
  input  logic       cmd_reset,
  input  logic       start_req,
  input  logic       transp_req,
  input  logic       end_req,
  input  logic       fifo_empty,
  input  logic       fifo_last,
  input  logic [7:0] fifo_data,
  output logic       fifo_rd,
  output logic       take_start,
  output logic       take_end,
  output logic       tx_bit,
  output logic       pool_irq,
  output logic       underrun_irq
);
  tx_state_e   state, n_state;
  logic [15:0] sh, n_sh, crc, crc_now, fill_word;
  logic [4:0]  cnt, n_cnt;
  logic [2:0]  ones, ones_nx;
  logic        stuff_pend, framed, n_framed, abort_rst, tx_q;
  logic        pool_q, under_q;

  // named internal events
  logic emit, stuff_bit, seg_done, stuffed_state, run_hit;
  logic underrun_ev, abort_done, pool_ev, data_pick;

  assign emit          = bit_en && !stuff_pend && !cmd_reset;
  assign stuff_bit     = bit_en &&  stuff_pend && !cmd_reset;
  assign seg_done      = emit && (cnt == 5'd1);
  assign stuffed_state = (state == S_DATA && framed) || (state == S_CRC);
  assign ones_nx       = run_next(ones, sh[0]);
  assign run_hit       = stuffed_state && (ones_nx == STUFF_RUN);
  assign crc_now       = (state == S_DATA && framed) ? crc_step(crc, sh[0]) : crc;
  assign fill_word     = idle_ones ? 16'h00FF : {8'h00, FLAG_BYTE};
  assign pool_ev       = fifo_rd && fifo_last && !end_req;

  always_comb begin
    n_state     = state;
    n_sh        = {1'b0, sh[15:1]};
    n_cnt       = cnt - 5'd1;
    n_framed    = framed;
    fifo_rd     = 1'b0;
    take_start  = 1'b0;
    take_end    = 1'b0;
    underrun_ev = 1'b0;
    abort_done  = 1'b0;
    data_pick   = 1'b0;
    if (seg_done) begin
      case (state)
        S_FILL: begin
          if (start_req) begin
            n_state = S_OPEN; n_sh = {8'h00, FLAG_BYTE}; n_cnt = 5'd8;
            take_start = 1'b1; n_framed = 1'b1;
          end else if (transp_req) begin
            take_start = 1'b1; n_framed = 1'b0; data_pick = 1'b1;
          end else begin
            n_sh = fill_word; n_cnt = 5'd8;
          end
        end
        S_OPEN, S_DATA: data_pick = 1'b1;
        S_CRC: begin
          n_state = S_CLOSE; n_sh = {8'h00, FLAG_BYTE}; n_cnt = 5'd8;
        end
        S_CLOSE: begin
          n_state = S_FILL; n_sh = fill_word; n_cnt = 5'd8;
        end
        default: begin
          n_state = S_FILL; n_sh = fill_word; n_cnt = 5'd8; abort_done = 1'b1;
        end
      endcase
      if (data_pick) begin
        if (!fifo_empty) begin
          n_state = S_DATA; n_sh = {8'h00, fifo_data}; n_cnt = 5'd8; fifo_rd = 1'b1;
        end else if (end_req) begin
          take_end = 1'b1;
          if (n_framed) begin
            n_state = S_CRC; n_sh = ~crc_now; n_cnt = 5'd16;
          end else begin
            n_state = S_FILL; n_sh = fill_word; n_cnt = 5'd8;
          end
        end else begin
          n_state = S_ABORT; n_sh = 16'h007F; n_cnt = 5'd7; underrun_ev = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_FILL;
      sh         <= {8'h00, FLAG_BYTE};
      cnt        <= 5'd8;
      ones       <= 3'd0;
      stuff_pend <= 1'b0;
      framed     <= 1'b1;
      crc        <= CRC_PRESET;
      abort_rst  <= 1'b0;
      tx_q       <= 1'b1;
      pool_q     <= 1'b0;
      under_q    <= 1'b0;
    end else begin
      pool_q  <= pool_ev || (abort_done && abort_rst);
      under_q <= underrun_ev;
      if (cmd_reset) begin
        state      <= S_ABORT;
        sh         <= 16'hFFFF;
        abort_rst  <= 1'b1;
        stuff_pend <= 1'b0;
        ones       <= 3'd0;
        if (bit_en) begin
          tx_q <= 1'b1;
          cnt  <= 5'd6;
        end else begin
          cnt  <= 5'd7;
        end
      end else if (stuff_bit) begin
        tx_q       <= 1'b0;
        stuff_pend <= 1'b0;
        ones       <= 3'd0;
      end else if (emit) begin
        tx_q   <= sh[0];
        state  <= n_state;
        sh     <= n_sh;
        cnt    <= n_cnt;
        framed <= n_framed;
        if (stuffed_state) begin
          ones       <= run_hit ? 3'd0 : ones_nx;
          stuff_pend <= run_hit;
        end else begin
          ones       <= 3'd0;
        end
        if (state == S_DATA && framed) crc <= crc_now;
        if (state == S_FILL && n_state == S_OPEN) crc <= CRC_PRESET;
        if (underrun_ev) abort_rst <= 1'b0;
      end
    end
  end

  assign tx_bit       = tx_q;
  assign pool_irq     = pool_q;
  assign underrun_irq = under_q;

  // R8: the line only moves on an enabled edge
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(tx_bit));

  // R2: a pending inserted zero goes out as 0
  p_stuff_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (stuff_pend && bit_en && !cmd_reset) |=> !tx_bit);

  // R6: an underrun leads into the abort pattern and is reported
  p_underrun_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
    underrun_ev |=> (state == S_ABORT) && underrun_irq);

  // R7: a reset strobe always lands in the abort pattern
  p_reset_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reset |=> (state == S_ABORT));

  // R5: the pool interrupt is a single-cycle pulse
  p_pool_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pool_irq |=> !pool_irq);

  // R3: the check sequence is followed by the closing flag
  p_crc_then_close_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_CRC && seg_done) |=> (state == S_CLOSE));
endmodule

// File: rtl/hdlc_cmd_tx.sv
module hdlc_cmd_tx #(
  parameter int DEPTH = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  input  logic       idle_ones,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       cmd_frame,
  input  logic       cmd_transp,
  input  logic       cmd_msg_end,
  input  logic       cmd_reset,
  output logic       tx_bit,
  output logic       pool_irq,
  output logic       underrun_irq
);
  logic       fifo_rd, fifo_empty, fifo_last;
  logic [7:0] fifo_data;
  logic       take_start, take_end, start_req, transp_req, end_req;

  hdlc_tx_fifo #(.DEPTH(DEPTH), .W(8)) u_fifo (
    .clk(clk), .rst_n(rst_n), .clr(cmd_reset),
    .wr(wr_en), .wdata(wr_data),
    .rd(fifo_rd), .rdata(fifo_data),
    .empty(fifo_empty), .last(fifo_last)
  );

  hdlc_tx_cmd u_cmd (
    .clk(clk), .rst_n(rst_n),
    .cmd_frame(cmd_frame), .cmd_transp(cmd_transp),
    .cmd_msg_end(cmd_msg_end), .cmd_reset(cmd_reset),
    .take_start(take_start), .take_end(take_end),
    .start_req(start_req), .transp_req(transp_req), .end_req(end_req)
  );

  hdlc_tx_serial u_ser (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .idle_ones(idle_ones),
    .cmd_reset(cmd_reset),
    .start_req(start_req), .transp_req(transp_req), .end_req(end_req),
    .fifo_empty(fifo_empty), .fifo_last(fifo_last), .fifo_data(fifo_data),
    .fifo_rd(fifo_rd), .take_start(take_start), .take_end(take_end),
    .tx_bit(tx_bit), .pool_irq(pool_irq), .underrun_irq(underrun_irq)
  );

  // R7: the reset strobe leaves the queue empty
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reset |=> fifo_empty);
endmodule

// File: tb/tb_hdlc_cmd_tx.sv
module tb_hdlc_cmd_tx;
  localparam int DEPTH = 32;
  localparam logic [7:0] FLAG = 8'h7E;

  logic clk = 1'b0, rst_n = 1'b0, bit_en = 1'b0, idle_ones = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic cmd_frame = 1'b0, cmd_transp = 1'b0, cmd_msg_end = 1'b0, cmd_reset = 1'b0;
  logic tx_bit, pool_irq, underrun_irq;

  always #2 clk = ~clk;

  hdlc_cmd_tx #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .idle_ones(idle_ones),
    .wr_en(wr_en), .wr_data(wr_data),
    .cmd_frame(cmd_frame), .cmd_transp(cmd_transp),
    .cmd_msg_end(cmd_msg_end), .cmd_reset(cmd_reset),
    .tx_bit(tx_bit), .pool_irq(pool_irq), .underrun_irq(underrun_irq)
  );

  int errors = 0, checks = 0;
  bit cap [0:16383];
  int cap_n = 0, mark = 0, pool_cnt = 0, und_cnt = 0, glitch = 0;
  bit en_last = 1'b0, last_tx = 1'b1;
  int en_div = 2, en_ph = 0;
  logic [7:0] dat [0:63];
  bit exp_bits [0:4095];
  int exp_n = 0, run = 0;

  // bit clock enable, driven just after each rising edge
  always @(posedge clk) begin
    #1;
    en_ph = en_ph + 1;
    bit_en = ((en_ph % en_div) == 0);
  end

  // line monitor, samples at the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (en_last) begin
        if (cap_n < 16384) cap[cap_n] = tx_bit;
        cap_n++;
      end else if (tx_bit !== last_tx) glitch++;
      if (pool_irq) pool_cnt++;
      if (underrun_irq) und_cnt++;
      if (cmd_frame || cmd_transp || cmd_reset) mark = cap_n;
    end
    last_tx = tx_bit;
    en_last = bit_en && rst_n;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic write_bytes(input int n);
    for (int i = 0; i < n; i++) begin
      wr_en = 1'b1; wr_data = dat[i]; tick();
    end
    wr_en = 1'b0;
  endtask

  task automatic strobe(input bit f, input bit t, input bit e, input bit r);
    cmd_frame = f; cmd_transp = t; cmd_msg_end = e; cmd_reset = r;
    tick();
    cmd_frame = 0; cmd_transp = 0; cmd_msg_end = 0; cmd_reset = 0;
  endtask

  task automatic wait_bits(input int target);
    while (cap_n < target) tick();
  endtask

  function automatic void push(input bit b, input bit st);
    exp_bits[exp_n] = b; exp_n++;
    if (st) begin
      if (b) run++; else run = 0;
      if (run == 5) begin exp_bits[exp_n] = 1'b0; exp_n++; run = 0; end
    end
  endfunction

  // frame check sequence restated bytewise
  function automatic logic [15:0] ref_fcs(input int n);
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < n; i++) begin
      c = c ^ {8'h00, dat[i]};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 16'h8408) : (c >> 1);
    end
    return ~c;
  endfunction

  function automatic void build(input int n, input bit framed, input bit aborted,
                                input bit ones_fill);
    logic [15:0] f;
    exp_n = 0; run = 0;
    if (framed) for (int k = 0; k < 8; k++) push(FLAG[k], 0);
    for (int i = 0; i < n; i++)
      for (int k = 0; k < 8; k++) push(dat[i][k], framed);
    if (aborted) begin
      for (int k = 0; k < 7; k++) push(1'b1, 0);
    end else if (framed) begin
      f = ref_fcs(n);
      for (int k = 0; k < 16; k++) push(f[k], 1);
      for (int k = 0; k < 8; k++) push(FLAG[k], 0);
    end
    for (int k = 0; k < 8; k++) push(ones_fill ? 1'b1 : FLAG[k], 0);
  endfunction

  function automatic int find(input int from, input int span);
    for (int p = from; p <= from + span; p++) begin
      bit ok = 1'b1;
      if (p + exp_n > cap_n || p + exp_n > 16384) ok = 1'b0;
      for (int j = 0; ok && j < exp_n; j++)
        if (cap[p + j] != exp_bits[j]) ok = 1'b0;
      if (ok) return p;
    end
    return -1;
  endfunction

  task automatic check_frame(input string req, input int n, input bit framed,
                             input bit aborted, input bit ones_fill);
    int pos;
    build(n, framed, aborted, ones_fill);
    wait_bits(mark + exp_n + 16);
    pos = find(mark, 12);
    check(pos >= 0, req, "expected bit pattern position", pos, mark);
  endtask

  initial begin
    #(4 * 190000);
    errors++; checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int p0, u0, ones_seen, flag_ok;
    void'($urandom(32'd4711));
    tick(); tick();
    check(tx_bit === 1'b1, "R1", "tx during reset", int'(tx_bit), 1);
    rst_n = 1'b1;

    // R1: idle flags
    wait_bits(24);
    flag_ok = 1;
    for (int i = 0; i < 24; i++) if (cap[i] != FLAG[i % 8]) flag_ok = 0;
    check(flag_ok == 1, "R1", "idle flag stream", flag_ok, 1);

    // R2 R3: directed frames with heavy zero insertion and flag-like data
    for (int i = 0; i < 6; i++) dat[i] = 8'hFF;
    p0 = pool_cnt;
    write_bytes(6); strobe(1, 0, 1, 0);
    check_frame("R2", 6, 1, 0, 0);
    for (int i = 0; i < 4; i++) dat[i] = (i % 2 == 0) ? FLAG : 8'h3E;
    en_div = 1;
    write_bytes(4); strobe(1, 0, 1, 0);
    check_frame("R3", 4, 1, 0, 0);
    check(pool_cnt == p0, "R5", "no pool pulse for complete message", pool_cnt - p0, 0);

    // R3: empty message carries only the check sequence
    en_div = 2;
    strobe(1, 0, 1, 0);
    check_frame("R3", 0, 1, 0, 0);

    // R4: transparent
    dat[0] = 8'hA5; dat[1] = 8'hFF; dat[2] = 8'h0F;
    write_bytes(3); strobe(0, 1, 1, 0);
    check_frame("R4", 3, 0, 0, 0);

    // R5: message in two chunks
    en_div = 4;
    for (int i = 0; i < 7; i++) dat[i] = 8'(8'h11 * (i + 1));
    p0 = pool_cnt;
    write_bytes(3); strobe(1, 0, 0, 0);
    while (pool_cnt == p0) tick();
    for (int i = 0; i < 4; i++) begin
      wr_en = 1'b1; wr_data = dat[3 + i]; tick();
    end
    wr_en = 1'b0;
    strobe(0, 0, 1, 0);
    check_frame("R5", 7, 1, 0, 0);
    check(pool_cnt == p0 + 1, "R5", "pool pulses for two-chunk frame", pool_cnt - p0, 1);

    // R6: underrun after the first chunk
    dat[0] = 8'h5A; dat[1] = 8'hF8;
    p0 = pool_cnt; u0 = und_cnt;
    write_bytes(2); strobe(1, 0, 0, 0);
    check_frame("R6", 2, 1, 1, 0);
    check(und_cnt == u0 + 1, "R6", "underrun pulses", und_cnt - u0, 1);
    check(pool_cnt == p0 + 1, "R5", "pool pulse before underrun", pool_cnt - p0, 1);

    // R7: reset mid-frame with an enabled bit on the same edge
    en_div = 1;
    for (int i = 0; i < 20; i++) dat[i] = 8'($urandom);
    write_bytes(20); strobe(1, 0, 1, 0);
    wait_bits(mark + 60);
    p0 = pool_cnt;
    strobe(0, 0, 0, 1);
    wait_bits(mark + 24);
    ones_seen = 0;
    for (int i = 0; i < 7; i++) if (cap[mark + i]) ones_seen++;
    check(ones_seen == 7, "R7", "abort ones after reset", ones_seen, 7);
    flag_ok = 1;
    for (int i = 0; i < 8; i++) if (cap[mark + 7 + i] != FLAG[i]) flag_ok = 0;
    check(flag_ok == 1, "R7", "fill flag after abort", flag_ok, 1);
    check(pool_cnt == p0 + 1, "R7", "pool pulse after reset", pool_cnt - p0, 1);
    dat[0] = 8'hC3;
    write_bytes(1); strobe(1, 0, 1, 0);
    check_frame("R7", 1, 1, 0, 0);

    // R9: two writes beyond capacity are dropped
    en_div = 2;
    for (int i = 0; i < DEPTH + 2; i++) dat[i] = 8'(i * 7 + 3);
    write_bytes(DEPTH + 2); strobe(1, 0, 1, 0);
    check_frame("R9", DEPTH, 1, 0, 0);

    // R1: all-ones fill
    idle_ones = 1'b1;
    p0 = cap_n;
    wait_bits(p0 + 24);
    ones_seen = 0;
    for (int i = 0; i < 8; i++) if (cap[cap_n - 8 + i]) ones_seen++;
    check(ones_seen == 8, "R1", "all-ones fill byte", ones_seen, 8);
    dat[0] = 8'h81; dat[1] = 8'h7F;
    write_bytes(2); strobe(1, 0, 1, 0);
    check_frame("R1", 2, 1, 0, 1);
    idle_ones = 1'b0;
    wait_bits(cap_n + 16);

    // R2 R3 R4 R5: random frames
    for (int t = 0; t < 8; t++) begin
      int n = 1 + int'($urandom % 24);
      bit fr = ($urandom % 4) != 0;
      en_div = 1 + int'($urandom % 3);
      for (int i = 0; i < n; i++)
        dat[i] = (($urandom % 3) == 0) ? 8'hFF : 8'($urandom);
      p0 = pool_cnt;
      write_bytes(n);
      strobe(fr, !fr, 1, 0);
      check_frame(fr ? "R2" : "R4", n, fr, 0, 0);
      check(pool_cnt == p0, "R5", "random frame pool pulses", pool_cnt - p0, 0);
    end

    check(glitch == 0, "R8", "line changes without bit_en", glitch, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule